// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block sits in front of a small shared word memory and serves several requesters, one request per clock. Besides ordinary loads and stores it offers a linked load, which returns the word and opens a reservation for that requester on that address. It also offers a conditional store. A conditional store writes only while the requester's reservation is still intact. It returns a pass or fail flag, so software can build atomic read-modify-write loops and locks on top of it.

Each requester holds one reservation: a valid flag and an address. A newer linked load from the same requester replaces the older reservation. Any write that lands on an address clears every reservation on that address, the writer's own included. Such a write is a plain store or a passing conditional store. A failing conditional store writes nothing and leaves every reservation as it was.

Requests use valid/ready. A requester holds `req_valid`, its opcode, address and data stable until it sees its `req_ready` high at a clock edge. A fixed-priority arbiter grants one requester per cycle, and the lowest index wins. Responses carry no back-pressure. A granted request always returns its response on the next cycle, and the requester must take it.

Top module: `resv_monitor`

## Requirements
- R1: At most one `req_ready` bit is high in a cycle. It is high only for a requester whose `req_valid` is high, and it picks the lowest-indexed valid requester.
- R2: A request granted at a clock edge raises exactly that requester's `rsp_valid` bit for the following cycle. `rsp_valid` is zero in any cycle after an edge with no grant.
- R3: Opcode 0 is LOAD. It returns the addressed word in `rsp_rdata` with `rsp_ok`=1.
- R4: Opcode 1 is STORE. It writes `wdata`, returns `rsp_ok`=1 and clears every requester's reservation on that address, including the storer's own.
- R5: Opcode 2 is LINKED LOAD. It returns the word with `rsp_ok`=1 and reserves that address for the requester, replacing any reservation the requester held before.
- R6: Opcode 3 is CONDITIONAL STORE. It passes when the requester holds a valid reservation on the same address. A pass writes the word, returns `rsp_ok`=1 and clears all reservations on that address.
- R7: A conditional store without a matching valid reservation returns `rsp_ok`=0. It writes nothing and changes no reservation.
- R8: When two requesters present conditional stores to the same reserved address in the same cycle, the lower index is served first and passes, and the other then fails.
- R9: After reset no reservation is held, `rsp_valid` is zero, and every memory word reads zero.
- R10: For STORE and CONDITIONAL STORE, `rsp_rdata` returns the word as it was before the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request valid per requester |
| req_op | input | 2*N_REQ | Opcode per requester (0 load, 1 store, 2 linked load, 3 conditional store) |
| req_addr | input | AW*N_REQ | Word address per requester |
| req_wdata | input | DW*N_REQ | Write data per requester |
| req_ready | output | N_REQ | Grant: request accepted at this edge |
| rsp_valid | output | N_REQ | Response strobe for the granted requester |
| rsp_rdata | output | DW | Word read at the time of the grant |
| rsp_ok | output | 1 | Pass flag (0 only for a failing conditional store) |

## Verification
The bench builds the block with three requesters, a four-word memory and 8-bit data. At that size it can run every combination of linked-load owner, intervening requester, intervening opcode and same-or-other address, and then close each combination with the owner's conditional store. This covers self-replacement, self-clearing by its own store and cross-requester breaking. Simultaneous requests check the priority order and the race between competing conditional stores. A model in the bench tracks memory words and reservations, so it computes every pass flag and data value without reference to the design.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } op_e;
endpackage

// File: rtl/resv_arb.sv
module resv_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] valid,
  output logic [N-1:0] gnt,
  output logic [IW-1:0] gidx,
  output logic         any
);
  always_comb begin
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && !any) begin
        gnt[i] = 1'b1;
        gidx   = IW'(i);
        any    = 1'b1;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)) else $error("more than one grant"); // R1
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((valid & (gnt - N'(1))) == '0)) else $error("grant skipped lower requester"); // R1
endmodule

// File: rtl/resv_table.sv
module resv_table #(
  parameter int N  = 4,
  parameter int AW = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ll_en,
  input  logic [IW-1:0] ll_id,
  input  logic [AW-1:0] ll_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [IW-1:0] chk_id,
  input  logic [AW-1:0] chk_addr,
  output logic          chk_hit
);
  logic [N-1:0]  ent_v;
  logic [AW-1:0] ent_a [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[g] <= 1'b0;
        ent_a[g] <= '0;
      end else if (ll_en && ll_id == IW'(g)) begin
        ent_v[g] <= 1'b1;
        ent_a[g] <= ll_addr;
      end else if (wr_en && ent_v[g] && ent_a[g] == wr_addr) begin
        ent_v[g] <= 1'b0;
      end
    end

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ll_en) |=> !(ent_v[g] && ent_a[g] == $past(wr_addr))) else $error("reservation survived write"); // R6
  end

  always_comb begin
    chk_hit = 1'b0;
    for (int i = 0; i < N; i++)
      if (chk_id == IW'(i)) chk_hit = ent_v[i] && ent_a[i] == chk_addr;
  end

  AST_LL_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
    ll_en |=> (ent_v[$past(ll_id)] && ent_a[$past(ll_id)] == $past(ll_addr))) else $error("linked load not recorded"); // R5
endmodule

// File: rtl/resv_mem.sv
module resv_mem #(
  parameter int AW = 3,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                         words[g] <= '0;
      else if (we && addr == AW'(g))      words[g] <= wdata;
    end
  end

  assign rdata = words[addr];
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int AW    = 3,
  parameter int DW    = 16,
  localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_REQ-1:0]    req_valid,
  input  logic [2*N_REQ-1:0]  req_op,
  input  logic [AW*N_REQ-1:0] req_addr,
  input  logic [DW*N_REQ-1:0] req_wdata,
  output logic [N_REQ-1:0]    req_ready,
  output logic [N_REQ-1:0]    rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_ok
);
  logic [N_REQ-1:0] gnt;
  logic [IW-1:0]    gidx;
  logic             any_gnt;
  op_e              sel_op;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    sel_wdata;
  logic             res_hit;
  logic             sc_pass;
  logic             mem_we;
  logic [DW-1:0]    mem_rdata;

  resv_arb #(.N(N_REQ), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .valid(req_valid),
    .gnt(gnt), .gidx(gidx), .any(any_gnt)
  );

  always_comb begin
    sel_op    = OP_LOAD;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt[i]) begin
        sel_op    = op_e'(req_op[2*i +: 2]);
        sel_addr  = req_addr[AW*i +: AW];
        sel_wdata = req_wdata[DW*i +: DW];
      end
    end
  end

  assign sc_pass = any_gnt && sel_op == OP_SC && res_hit;
  assign mem_we  = any_gnt && (sel_op == OP_STORE || sc_pass);

  resv_table #(.N(N_REQ), .AW(AW), .IW(IW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .ll_en(any_gnt && sel_op == OP_LL), .ll_id(gidx), .ll_addr(sel_addr),
    .wr_en(mem_we), .wr_addr(sel_addr),
    .chk_id(gidx), .chk_addr(sel_addr), .chk_hit(res_hit)
  );

  resv_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(sel_addr),
    .wdata(sel_wdata), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_rdata <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= gnt;
      if (any_gnt) begin
        rsp_rdata <= mem_rdata;
        rsp_ok    <= (sel_op != OP_SC) || res_hit;
      end
    end
  end

  assign req_ready = gnt;

  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(req_ready)) else $error("response strobe mismatch"); // R2
  AST_SC_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && sel_op == OP_SC && !res_hit) |-> !mem_we) else $error("failing conditional store wrote"); // R7
endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;
  localparam int N  = 3;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      req_valid = '0;
  logic [2*N-1:0]    req_op = '0;
  logic [AW*N-1:0]   req_addr = '0;
  logic [DW*N-1:0]   req_wdata = '0;
  logic [N-1:0]      req_ready;
  logic [N-1:0]      rsp_valid;
  logic [DW-1:0]     rsp_rdata;
  logic              rsp_ok;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] m_mem [DEPTH];
  logic          m_v [N];
  int            m_a [N];
  logic [DW-1:0] next_wd = 8'h11;

  always #5 clk = ~clk;

  resv_monitor #(.N_REQ(N), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // model step: returns expected ok and data
  task automatic model(int k, int op, int a, logic [DW-1:0] wd,
                       output int eok, output int edat);
    edat = m_mem[a];
    eok  = 1;
    if (op == 2) begin
      m_v[k] = 1'b1; m_a[k] = a;
    end else if (op == 1 || op == 3) begin
      if (op == 3) eok = (m_v[k] && m_a[k] == a) ? 1 : 0;
      if (eok == 1) begin
        m_mem[a] = wd;
        for (int i = 0; i < N; i++) if (m_a[i] == a) m_v[i] = 1'b0;
      end
    end
  endtask

  task automatic put(int k, int op, int a, logic [DW-1:0] wd);
    req_valid[k] = 1'b1;
    req_op[2*k +: 2] = 2'(op);
    req_addr[AW*k +: AW] = AW'(a);
    req_wdata[DW*k +: DW] = wd;
  endtask

  task automatic single(int k, int op, int a, string req);
    int eok, edat;
    logic [DW-1:0] wd;
    wd = next_wd; next_wd = next_wd + 8'h07;
    @(negedge clk);
    put(k, op, a, wd);
    #1 check("R1 ready", int'(req_ready), 1 << k);
    model(k, op, a, wd, eok, edat);
    @(negedge clk);
    req_valid = '0;
    check("R2 rsp_valid", int'(rsp_valid), 1 << k);
    check(req, int'(rsp_ok), eok);
    check({req, " data (R10)"}, int'(rsp_rdata), edat);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_a[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 rsp_valid after reset", int'(rsp_valid), 0);
    check("R9 no ready idle", int'(req_ready), 0);
    for (int a = 0; a < DEPTH; a++) single(0, 0, a, "R9 R3 load zero");
    single(1, 3, 0, "R9 R7 sc without reservation");
    single(1, 0, 0, "R7 no write after failed sc");
    @(negedge clk);
    check("R2 idle after response", int'(rsp_valid), 0);

    // sweep: owner LL at a, other op at b, owner SC at a
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        for (int op = 0; op < 4; op++)
          for (int s = 0; s < 2; s++) begin
            int a, b;
            a = (i + j + op) % DEPTH;
            b = (s == 0) ? a : (a + 1) % DEPTH;
            single(i, 2, a, "R5 linked load");
            if (op == 3) single(j, 2, b, "R5 setup");
            single(j, op, b, "R4 R6 R7 intervening op");
            single(i, 3, a, "R6 R7 owner sc outcome");
            single(i, 0, a, "R3 load back");
          end

    // R1 priority with all valid, R8 competing sc
    single(1, 2, 2, "R5 ll r1");
    single(2, 2, 2, "R5 ll r2");
    @(negedge clk);
    put(2, 3, 2, 8'hA5);
    put(1, 3, 2, 8'h5A);
    #1 check("R1 lowest wins", int'(req_ready), 2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    check("R8 first sc rsp", int'(rsp_valid), 2);
    check("R8 first sc pass", int'(rsp_ok), 1);
    #1 check("R1 next ready", int'(req_ready), 4);
    @(negedge clk);
    req_valid = '0;
    check("R8 second sc rsp", int'(rsp_valid), 4);
    check("R8 second sc fails", int'(rsp_ok), 0);
    m_mem[2] = 8'h5A; m_v[1] = 1'b0; m_v[2] = 1'b0;
    single(0, 0, 2, "R8 winner data kept");
    single(0, 2, 3, "R5 ll");
    single(0, 2, 1, "R5 ll replaces");
    single(0, 3, 3, "R5 old reservation gone");
    single(0, 3, 1, "R5 new reservation passes");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule